// File: doc/BRIEF.md
# Iterative Shift-Add / Booth Multiplier

This block forms a 2W-bit product from two W-bit operands, one bit of the multiplier per clock. A mode input chooses between unsigned shift-add and signed two's-complement radix-2 Booth recoding. Area is kept small because the multiplier and the low half of the product live in one shift register: every iteration moves the accumulator's bottom bit into the top of that register while the used multiplier bit leaves at the bottom.

A pulse on `start` while idle latches the operands and the mode. `busy` then stays high for W cycles, `done` pulses for one cycle after the last iteration, and `product` holds its value until the next accepted start. The accumulator carries one guard bit above W. In unsigned mode this guard bit catches the carry of the add. In signed mode it keeps the sign, so the most-negative multiplicand still yields the exact full-width product.

Top module: `iter_mult`

## Requirements
- R1: A `start` seen while `busy` is low, including the cycle in which `done` is high, is accepted: the operands and mode are latched and `busy` is high in the next cycle with `done` low.
- R2: An accepted operation keeps `busy` high for exactly W cycles. In the cycle after the last one, `busy` is low and `done` is high for exactly one cycle.
- R3: With `signed_mode` = 0, `product` at `done` equals the unsigned product of `mcand` and `mplier`, zero-extended to 2W bits.
- R4: With `signed_mode` = 1, the operands are read as two's complement and `product` at `done` is their exact 2W-bit two's-complement product. This holds when either operand is the most negative value (bit W-1 set, all other bits clear).
- R5: A `start` seen while `busy` is high is ignored. The running operation finishes with its own result and no extra `done` follows.
- R6: While the block is idle and no start is accepted, `product` does not change, whatever `mcand`, `mplier` and `signed_mode` do.
- R7: During and right after an active-low reset, `busy` = 0, `done` = 0 and `product` = 0.
- R8: `done` is raised only in the cycle right after a cycle with `busy` high. It is never raised without an accepted operation.
- R9: Changes on `mcand`, `mplier` or `signed_mode` while `busy` is high do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| signed_mode | input | 1 | 1 = signed Booth, 0 = unsigned shift-add |
| mcand | input | W | Multiplicand |
| mplier | input | W | Multiplier |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle result strobe |
| product | output | 2W | Product, {high half, low half} |

## Verification
At W=8 the bench runs every multiplicand against a spread of multipliers that includes 0, 1, all ones and the most-negative pattern, in both modes. At W=16 it runs the corner pairs and random pairs. A design without the guard bit would give wrong upper bits for -128 x -128 or 0x8000 x 0x8000 in signed mode, and would lose the carry on large unsigned products such as 0xFF x 0xFF. Restarts and operand changes are injected in the middle of a run: a design that does not latch its inputs, or that accepts `start` while busy, returns the wrong product or an extra `done`. The bench also counts the cycles to `done` and checks that `product` holds while idle, which catches off-by-one iteration counts and an output that follows the inputs.

// File: rtl/iter_mult_pkg.sv
package iter_mult_pkg;
    // Action applied to the accumulator in one iteration
    typedef enum logic [1:0] {
        ACC_HOLD = 2'd0,
        ACC_ADD  = 2'd1,
        ACC_SUB  = 2'd2
    } acc_op_e;
endpackage

// File: rtl/iter_mult_recode.sv
module iter_mult_recode
    import iter_mult_pkg::*;
(
    input  logic    is_signed,
    input  logic    cur_bit,
    input  logic    prev_bit,
    output acc_op_e op
);
    always_comb begin
        op = ACC_HOLD;
        if (is_signed) begin
            // radix-2 Booth: 01 -> add, 10 -> subtract, 00/11 -> hold
            unique case ({cur_bit, prev_bit})
                2'b01:   op = ACC_ADD;
                2'b10:   op = ACC_SUB;
                default: op = ACC_HOLD;
            endcase
        end else if (cur_bit) begin
            op = ACC_ADD;
        end
    end
endmodule

// File: rtl/iter_mult_step.sv
module iter_mult_step
    import iter_mult_pkg::*;
#(
    parameter int W = 8
) (
    input  acc_op_e      op,
    input  logic         is_signed,
    input  logic [W:0]   acc,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] mc,
    output logic [W:0]   acc_nx,
    output logic [W-1:0] lo_nx
);
    logic [W:0] mc_ext;
    logic [W:0] sum;
    logic       fill;

    always_comb begin
        mc_ext = {is_signed & mc[W-1], mc};
        unique case (op)
            ACC_ADD: sum = acc + mc_ext;
            ACC_SUB: sum = acc - mc_ext;
            default: sum = acc;
        endcase
        // signed: replicate sign; unsigned: carry sits in sum[W], fill with zero
        fill   = is_signed ? sum[W] : 1'b0;
        acc_nx = {fill, sum[W:1]};
        lo_nx  = {sum[0], lo[W-1:1]};
    end
endmodule

// File: rtl/iter_mult_ctrl.sv
module iter_mult_ctrl #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    output logic load,
    output logic step
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        load       = start && !ctl_q.busy;
        step       = ctl_q.busy;
        if (load) begin
            ctl_d.busy = 1'b1;
            ctl_d.cnt  = CW'(W);
        end else if (ctl_q.busy) begin
            ctl_d.cnt = ctl_q.cnt - CW'(1);
            if (ctl_q.cnt == CW'(1)) begin
                ctl_d.busy = 1'b0;
                ctl_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign busy = ctl_q.busy;
    assign done = ctl_q.done;
endmodule

// File: rtl/iter_mult.sv
module iter_mult
    import iter_mult_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           signed_mode,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] product
);
    typedef struct packed {
        logic [W:0]   acc;   // high half plus guard bit
        logic [W-1:0] lo;    // multiplier, turning into low half
        logic [W-1:0] mc;
        logic         sgn;
        logic         prev;
    } dp_t;

    dp_t          dp_d, dp_q;
    logic         load, step;
    acc_op_e      op;
    logic [W:0]   acc_nx;
    logic [W-1:0] lo_nx;

    iter_mult_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done),
        .load  (load),
        .step  (step)
    );

    iter_mult_recode u_recode (
        .is_signed (dp_q.sgn),
        .cur_bit   (dp_q.lo[0]),
        .prev_bit  (dp_q.prev),
        .op        (op)
    );

    iter_mult_step #(.W(W)) u_step (
        .op        (op),
        .is_signed (dp_q.sgn),
        .acc       (dp_q.acc),
        .lo        (dp_q.lo),
        .mc        (dp_q.mc),
        .acc_nx    (acc_nx),
        .lo_nx     (lo_nx)
    );

    always_comb begin
        dp_d = dp_q;
        if (load) begin
            dp_d.acc  = '0;
            dp_d.lo   = mplier;
            dp_d.mc   = mcand;
            dp_d.sgn  = signed_mode;
            dp_d.prev = 1'b0;
        end else if (step) begin
            dp_d.acc  = acc_nx;
            dp_d.lo   = lo_nx;
            dp_d.prev = dp_q.lo[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign product = {dp_q.acc[W-1:0], dp_q.lo};
endmodule

// File: rtl/iter_mult_chk.sv
module iter_mult_chk #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           signed_mode,
    input logic [W-1:0]   mcand,
    input logic [W-1:0]   mplier,
    input logic           busy,
    input logic           done,
    input logic [2*W-1:0] product
);
    localparam int PW = 2 * W;
    localparam int CW = $clog2(W + 2);

    logic [PW-1:0] ax, bx, exp_q;
    logic          sgn_cap;
    logic [CW-1:0] run_cnt;

    assign ax = {{W{signed_mode & mcand[W-1]}}, mcand};
    assign bx = {{W{signed_mode & mplier[W-1]}}, mplier};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_q   <= '0;
            sgn_cap <= 1'b0;
            run_cnt <= '0;
        end else if (start && !busy) begin
            exp_q   <= ax * bx;
            sgn_cap <= signed_mode;
            run_cnt <= '0;
        end else if (busy) begin
            run_cnt <= run_cnt + CW'(1);
        end
    end

    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy && !done);

    p_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> run_cnt == CW'(W));

    p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_uprod_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done && !sgn_cap |-> product == exp_q);

    // R9: the expectation is latched at acceptance, so mid-run input changes are covered
    p_sprod_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done && sgn_cap |-> product == exp_q);

    p_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> busy ^ done);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(product));

    p_done_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    always_comb begin
        if (!rst_n) begin
            a_reset_r7: assert (!done) else $error("done during reset");
        end
    end
endmodule

bind iter_mult iter_mult_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .signed_mode (signed_mode),
    .mcand       (mcand),
    .mplier      (mplier),
    .busy        (busy),
    .done        (done),
    .product     (product)
);

// File: tb/iter_mult_test.sv
module iter_mult_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    // W=8 instance
    logic        st8 = 1'b0, sm8 = 1'b0;
    logic [7:0]  mc8 = '0, mp8 = '0;
    logic        busy8, done8;
    logic [15:0] prod8;
    // W=16 instance
    logic        st16 = 1'b0, sm16 = 1'b0;
    logic [15:0] mc16 = '0, mp16 = '0;
    logic        busy16, done16;
    logic [31:0] prod16;

    iter_mult #(.W(8)) uut (
        .clk(clk), .rst_n(rst_n), .start(st8), .signed_mode(sm8),
        .mcand(mc8), .mplier(mp8), .busy(busy8), .done(done8), .product(prod8)
    );

    iter_mult #(.W(16)) uut16 (
        .clk(clk), .rst_n(rst_n), .start(st16), .signed_mode(sm16),
        .mcand(mc16), .mplier(mp16), .busy(busy16), .done(done16), .product(prod16)
    );

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    logic [15:0] q8[$];
    logic        qm8[$];
    logic [31:0] q16[$];
    logic        qm16[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic logic [15:0] exp8(input logic [7:0] a, input logic [7:0] b, input logic m);
        logic [15:0] ax, bx;
        ax = m ? {{8{a[7]}}, a} : {8'h00, a};
        bx = m ? {{8{b[7]}}, b} : {8'h00, b};
        return ax * bx;
    endfunction

    function automatic logic [31:0] exp16(input logic [15:0] a, input logic [15:0] b, input logic m);
        logic [31:0] ax, bx;
        ax = m ? {{16{a[15]}}, a} : {16'h0000, a};
        bx = m ? {{16{b[15]}}, b} : {16'h0000, b};
        return ax * bx;
    endfunction

    // scoreboard monitors (R3/R4 product, R8 no unexpected done)
    always @(negedge clk) begin
        if (rst_n && done8) begin
            if (q8.size() == 0) chk(1'b0, "R8 spurious done W8", 32'(prod8), 32'h0);
            else begin
                logic [15:0] e;
                logic        m;
                e = q8.pop_front();
                m = qm8.pop_front();
                chk(prod8 == e, m ? "R4 signed W8" : "R3 unsigned W8", 32'(prod8), 32'(e));
            end
        end
        if (rst_n && done16) begin
            if (q16.size() == 0) chk(1'b0, "R8 spurious done W16", prod16, 32'h0);
            else begin
                logic [31:0] e;
                logic        m;
                e = q16.pop_front();
                m = qm16.pop_front();
                chk(prod16 == e, m ? "R4 signed W16" : "R3 unsigned W16", prod16, e);
            end
        end
    end

    // driver, W=8; poke injects a start and new inputs mid-run (R5, R9)
    task automatic run8(input logic [7:0] a, input logic [7:0] b, input logic m, input bit poke);
        int n;
        q8.push_back(exp8(a, b, m));
        qm8.push_back(m);
        mc8 = a; mp8 = b; sm8 = m; st8 = 1'b1;
        @(negedge clk);
        st8 = 1'b0;
        chk(busy8 && !done8, "R1 accept W8", {30'h0, busy8, done8}, 32'h2);
        n = 1;
        while (!done8 && n < 40) begin
            @(negedge clk);
            n++;
            if (poke && n == 3) begin
                st8 = 1'b1; mc8 = ~a; mp8 = b ^ 8'h5A; sm8 = ~m;
            end else st8 = 1'b0;
        end
        st8 = 1'b0;
        chk(n == 9 && !busy8, "R2 length W8", 32'(n), 32'd9);
    endtask

    task automatic run16(input logic [15:0] a, input logic [15:0] b, input logic m, input bit poke);
        int n;
        q16.push_back(exp16(a, b, m));
        qm16.push_back(m);
        mc16 = a; mp16 = b; sm16 = m; st16 = 1'b1;
        @(negedge clk);
        st16 = 1'b0;
        chk(busy16 && !done16, "R1 accept W16", {30'h0, busy16, done16}, 32'h2);
        n = 1;
        while (!done16 && n < 60) begin
            @(negedge clk);
            n++;
            if (poke && (n == 4 || n == 10)) begin
                st16 = 1'b1; mc16 = ~a; mp16 = b ^ 16'hA5C3; sm16 = ~m;
            end else st16 = 1'b0;
        end
        st16 = 1'b0;
        chk(n == 17 && !busy16, "R2 length W16", 32'(n), 32'd17);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        logic [7:0]  mset [16];
        logic [15:0] cset [6];
        logic [15:0] held;
        mset = '{8'h00, 8'h01, 8'h02, 8'h7F, 8'h80, 8'h81, 8'hFF, 8'h55,
                 8'hAA, 8'h0F, 8'hF0, 8'h3C, 8'hC3, 8'h7E, 8'hFE, 8'h40};
        cset = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h8001};

        repeat (3) @(negedge clk);
        // R7: reset state
        chk(!busy8 && !done8 && prod8 == 16'h0, "R7 reset W8", 32'(prod8), 32'h0);
        chk(!busy16 && !done16 && prod16 == 32'h0, "R7 reset W16", prod16, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy8 && !done8 && prod8 == 16'h0, "R7 after reset", 32'(prod8), 32'h0);

        // R4 most-negative corners first
        run8(8'h80, 8'h80, 1'b1, 1'b0);
        run8(8'h80, 8'h7F, 1'b1, 1'b0);
        run8(8'hFF, 8'hFF, 1'b0, 1'b0);

        // R2 single-cycle pulse, R6 hold while idle with inputs moving
        @(negedge clk);
        chk(!done8 && !busy8, "R2 done one cycle", {31'h0, done8}, 32'h0);
        held = prod8;
        for (int i = 0; i < 4; i++) begin
            mc8 = 8'(i * 37); mp8 = 8'(i * 91); sm8 = i[0];
            @(negedge clk);
            chk(prod8 == held && !done8, "R6 hold idle", 32'(prod8), 32'(held));
        end

        // W=8 sweep: all multiplicands x multiplier set, both modes
        for (int m = 0; m < 2; m++)
            for (int a = 0; a < 256; a++)
                for (int k = 0; k < 16; k++)
                    run8(8'(a), mset[k], m[0], (k == 5));

        // W=16 corner pairs, with and without mid-run disturbance (R5, R9)
        for (int m = 0; m < 2; m++)
            for (int i = 0; i < 6; i++)
                for (int j = 0; j < 6; j++)
                    run16(cset[i], cset[j], m[0], (j == 2));

        // W=16 random pairs
        for (int r = 0; r < 600; r++)
            run16(16'($urandom), 16'($urandom), r[0], (r % 3 == 0));

        repeat (4) @(negedge clk);
        chk(q8.size() == 0, "R2 all W8 results delivered", 32'(q8.size()), 32'h0);
        chk(q16.size() == 0, "R2 all W16 results delivered", 32'(q16.size()), 32'h0);
        chk(!done16 && !busy16, "R8 quiet at end", {30'h0, busy16, done16}, 32'h0);
        finish_run();
    end
endmodule